// File: doc/BRIEF.md
# Configurable Output Logic Macrocell

This block is the output stage that sits behind a programmable AND/OR array. Each lane takes one sum-of-products term and one output-enable term. It produces a pad driver, made of a data value and an enable, and a feedback bit that returns to the array. Every lane has two configuration bits. One picks registered or combinational operation. The other picks true or inverted polarity at the pad.

All lanes share a clear term and a preset term. The clear term zeroes every lane's flip-flop at once, with no clock needed. The preset term sets every flip-flop to one at the next rising clock edge. Both terms act on the flip-flop state and not on the pad level, so after a clear a lane set to inverted polarity shows a high pad.

The feedback source depends on the mode. A registered lane feeds back the complement of its flip-flop and ignores the pad. A combinational lane feeds back what is on the pin: its own driven value while the enable is on, and the externally supplied pad level while it is off. The pad is split into a driven value, an enable and an incoming level, so the high-impedance state is the enable being low.

Top module: `olmc_array`

## Requirements
- R1: A registered lane (cfg_registered bit = 1) loads its sum term into its flip-flop on each rising clock edge when clear and preset are both low, and its pad value comes from that flip-flop.
- R2: A combinational lane (cfg_registered bit = 0) drives its pad value from its sum term in the same cycle, with no clock involved.
- R3: When a lane's cfg_invert bit is 1, its pad value is the complement of the selected source. When the bit is 0, the pad value equals the source. This holds in both modes.
- R4: While clr_term is high, every flip-flop is 0 at once, before any clock edge.
- R5: When set_term is high and clr_term is low at a rising clock edge, every flip-flop becomes 1.
- R6: When clr_term and set_term are high together, the flip-flops stay 0. Neither the preset nor the sum term is loaded.
- R7: Clear and preset fix the flip-flop value whatever the polarity. After a clear, a registered inverted lane drives pad value 1 and a registered true lane drives 0.
- R8: A registered lane's feedback is the complement of its flip-flop and does not depend on pad_in or oe_term.
- R9: A combinational lane's feedback equals its own pad value while its oe_term bit is 1, and equals its pad_in bit while oe_term is 0.
- R10: Each lane's pad_oe equals its oe_term bit. A term held at 1 makes a dedicated output, and a term held at 0 makes a dedicated input.
- R11: While rst_n is low, every flip-flop is 0, and set_term has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock for the flip-flops |
| rst_n | input | 1 | Active-low reset, clears all flip-flops |
| clr_term | input | 1 | Shared asynchronous clear term |
| set_term | input | 1 | Shared synchronous preset term |
| sum_term | input | LANES | Sum-of-products term per lane |
| oe_term | input | LANES | Output-enable term per lane |
| cfg_registered | input | LANES | 1 = registered lane, 0 = combinational lane |
| cfg_invert | input | LANES | 1 = inverted pad polarity |
| pad_in | input | LANES | Level seen on each pin from outside |
| pad_out | output | LANES | Value driven onto each pin |
| pad_oe | output | LANES | Driver enable per pin, 0 = high impedance |
| fb_out | output | LANES | Feedback bit per lane into the array |

## Verification
The bench builds the block with LANES = 3. Three lanes are enough to hold registered and combinational lanes, and true and inverted lanes, side by side in one cycle. That lets a single shared clear or preset be checked against lanes of different polarity in the same cycle. With three lanes, one lane can also be enabled while its neighbours are disabled, which separates the two combinational feedback sources. The bench asserts the clear between clock edges and samples before the next edge, so the clear is seen to act without a clock.

// File: rtl/olmc_pkg.sv
package olmc_pkg;

  // Pad value from the selected source and the lane polarity bit.
  function automatic logic pol_apply(input logic src, input logic invert);
    return src ^ invert;
  endfunction

  // Feedback source: complemented flop in registered mode, pin otherwise.
  function automatic logic fb_select(input logic registered, input logic flop_q,
                                     input logic enabled, input logic driven,
                                     input logic pin_level);
    logic pin_side;
    pin_side = enabled ? driven : pin_level;
    return registered ? ~flop_q : pin_side;
  endfunction

endpackage

// File: rtl/olmc_flops.sv
module olmc_flops #(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_term,
  input  logic             set_term,
  input  logic [LANES-1:0] d,
  output logic [LANES-1:0] q
);

  logic clear_now;
  assign clear_now = clr_term | ~rst_n;

  // Clear is asynchronous and dominant; preset waits for the edge.
  always_ff @(posedge clk or posedge clear_now) begin
    if (clear_now)     q <= '0;
    else if (set_term) q <= '1;
    else               q <= d;
  end

endmodule

// File: rtl/olmc_lane.sv
module olmc_lane
  import olmc_pkg::*;
(
  input  logic sum_bit,
  input  logic oe_bit,
  input  logic registered,
  input  logic invert,
  input  logic flop_q,
  input  logic pin_level,
  output logic drv,
  output logic drv_en,
  output logic fb
);

  logic src;

  assign src    = registered ? flop_q : sum_bit;
  assign drv    = pol_apply(src, invert);
  assign drv_en = oe_bit;
  assign fb     = fb_select(registered, flop_q, oe_bit, drv, pin_level);

endmodule

// File: rtl/olmc_array.sv
module olmc_array #(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_term,
  input  logic             set_term,
  input  logic [LANES-1:0] sum_term,
  input  logic [LANES-1:0] oe_term,
  input  logic [LANES-1:0] cfg_registered,
  input  logic [LANES-1:0] cfg_invert,
  input  logic [LANES-1:0] pad_in,
  output logic [LANES-1:0] pad_out,
  output logic [LANES-1:0] pad_oe,
  output logic [LANES-1:0] fb_out
);

  // Named flop state, brought out for the checker.
  logic [LANES-1:0] flop_state;

  olmc_flops #(.LANES(LANES)) u_flops (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_term (clr_term),
    .set_term (set_term),
    .d        (sum_term),
    .q        (flop_state)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    olmc_lane u_lane (
      .sum_bit    (sum_term[i]),
      .oe_bit     (oe_term[i]),
      .registered (cfg_registered[i]),
      .invert     (cfg_invert[i]),
      .flop_q     (flop_state[i]),
      .pin_level  (pad_in[i]),
      .drv        (pad_out[i]),
      .drv_en     (pad_oe[i]),
      .fb         (fb_out[i])
    );
  end

endmodule

// File: rtl/olmc_array_chk.sv
module olmc_array_chk #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr_term,
  input logic             set_term,
  input logic [LANES-1:0] sum_term,
  input logic [LANES-1:0] oe_term,
  input logic [LANES-1:0] cfg_registered,
  input logic [LANES-1:0] pad_in,
  input logic [LANES-1:0] pad_out,
  input logic [LANES-1:0] fb_out,
  input logic [LANES-1:0] flop_state
);

  // R4
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_term |-> (flop_state == '0));

  // R5
  preset_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_term && !clr_term) |=> (clr_term || flop_state == '1));

  // R6
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_term && clr_term) |=> (flop_state == '0 || set_term));

  // R1
  reg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_term && !clr_term) |=> (clr_term || flop_state == $past(sum_term)));

  // R8
  fb_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((fb_out & cfg_registered) == (~flop_state & cfg_registered)));

  // R9
  fb_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (((fb_out ^ pad_out) & ~cfg_registered & oe_term) == '0) &&
    (((fb_out ^ pad_in) & ~cfg_registered & ~oe_term) == '0));

endmodule

bind olmc_array olmc_array_chk #(.LANES(LANES)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .clr_term       (clr_term),
  .set_term       (set_term),
  .sum_term       (sum_term),
  .oe_term        (oe_term),
  .cfg_registered (cfg_registered),
  .pad_in         (pad_in),
  .pad_out        (pad_out),
  .fb_out         (fb_out),
  .flop_state     (flop_state)
);

// File: tb/olmc_array_bench.sv
module olmc_array_bench;
  localparam int N = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr_term = 1'b0, set_term = 1'b0;
  logic [N-1:0] sum_term = '0, oe_term = '0, cfg_registered = '0;
  logic [N-1:0] cfg_invert = '0, pad_in = '0;
  logic [N-1:0] pad_out, pad_oe, fb_out;

  int compared = 0;
  int mismatched = 0;
  logic [N-1:0] mq = '0;   // behavioural flop state

  always #10 clk = ~clk;  // 50 MHz

  olmc_array #(.LANES(N)) u_olmc_array (
    .clk(clk), .rst_n(rst_n), .clr_term(clr_term), .set_term(set_term),
    .sum_term(sum_term), .oe_term(oe_term), .cfg_registered(cfg_registered),
    .cfg_invert(cfg_invert), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .fb_out(fb_out)
  );

  task automatic cmp(input string tag, input string what,
                     input logic [N-1:0] act, input logic [N-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    logic [N-1:0] eo, ef;
    for (int i = 0; i < N; i++) begin
      logic v;
      v = cfg_registered[i] ? mq[i] : sum_term[i];
      eo[i] = cfg_invert[i] ? ~v : v;
      if (cfg_registered[i]) ef[i] = ~mq[i];
      else                   ef[i] = oe_term[i] ? eo[i] : pad_in[i];
    end
    cmp(tag, "pad_out", pad_out, eo);
    cmp(tag, "pad_oe", pad_oe, oe_term);
    cmp(tag, "fb_out", fb_out, ef);
  endtask

  task automatic step(input string tag, input logic clr, input logic set,
                      input logic [N-1:0] s, input logic [N-1:0] oe,
                      input logic [N-1:0] rg, input logic [N-1:0] inv,
                      input logic [N-1:0] pin);
    @(negedge clk);
    clr_term = clr; set_term = set; sum_term = s; oe_term = oe;
    cfg_registered = rg; cfg_invert = inv; pad_in = pin;
    #1;
    if (clr || !rst_n) mq = '0;   // clear acts with no clock
    check_all(tag);
    @(posedge clk);
    if (clr || !rst_n) mq = '0;
    else if (set)      mq = '1;
    else               mq = s;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    // R11: reset holds flops at 0 even with preset high
    step("R11", 1'b0, 1'b1, 3'b111, 3'b111, 3'b111, 3'b010, 3'b000);
    step("R11", 1'b0, 1'b1, 3'b111, 3'b111, 3'b111, 3'b000, 3'b000);
    @(negedge clk); rst_n = 1'b1;
    // R2: combinational, true polarity
    step("R2", 1'b0, 1'b0, 3'b101, 3'b111, 3'b000, 3'b000, 3'b000);
    step("R2", 1'b0, 1'b0, 3'b010, 3'b111, 3'b000, 3'b000, 3'b111);
    // R3: combinational, inverted
    step("R3", 1'b0, 1'b0, 3'b011, 3'b111, 3'b000, 3'b111, 3'b000);
    // R1: registered loading, pad follows flop a cycle later
    step("R1", 1'b0, 1'b0, 3'b110, 3'b111, 3'b111, 3'b000, 3'b000);
    step("R1", 1'b0, 1'b0, 3'b011, 3'b111, 3'b111, 3'b000, 3'b000);
    step("R1", 1'b0, 1'b0, 3'b000, 3'b111, 3'b111, 3'b000, 3'b000);
    // R3: registered with mixed polarity
    step("R3", 1'b0, 1'b0, 3'b101, 3'b111, 3'b111, 3'b010, 3'b000);
    step("R3", 1'b0, 1'b0, 3'b101, 3'b111, 3'b111, 3'b010, 3'b000);
    // R5: preset
    step("R5", 1'b0, 1'b1, 3'b000, 3'b111, 3'b111, 3'b000, 3'b000);
    step("R5", 1'b0, 1'b0, 3'b000, 3'b111, 3'b111, 3'b000, 3'b000);
    // reload ones, then R4/R7: clear mid-cycle, inverted lanes go high
    step("R5", 1'b0, 1'b1, 3'b000, 3'b111, 3'b111, 3'b101, 3'b000);
    step("R4", 1'b1, 1'b0, 3'b111, 3'b111, 3'b111, 3'b101, 3'b000);
    step("R7", 1'b0, 1'b1, 3'b000, 3'b111, 3'b111, 3'b101, 3'b000);
    step("R7", 1'b1, 1'b0, 3'b111, 3'b111, 3'b111, 3'b101, 3'b000);
    // R6: clear and preset together
    step("R6", 1'b1, 1'b1, 3'b111, 3'b111, 3'b111, 3'b000, 3'b000);
    step("R6", 1'b0, 1'b0, 3'b010, 3'b111, 3'b111, 3'b000, 3'b000);
    // R8: registered feedback ignores pad_in and enable
    step("R8", 1'b0, 1'b0, 3'b100, 3'b000, 3'b111, 3'b000, 3'b111);
    step("R8", 1'b0, 1'b0, 3'b011, 3'b010, 3'b111, 3'b110, 3'b000);
    step("R8", 1'b0, 1'b0, 3'b011, 3'b101, 3'b111, 3'b011, 3'b101);
    // R9: combinational feedback from pin side
    step("R9", 1'b0, 1'b0, 3'b000, 3'b010, 3'b000, 3'b000, 3'b101);
    step("R9", 1'b0, 1'b0, 3'b111, 3'b010, 3'b000, 3'b010, 3'b000);
    step("R9", 1'b0, 1'b0, 3'b101, 3'b000, 3'b000, 3'b111, 3'b010);
    // R10: enable per lane, dedicated output and input
    step("R10", 1'b0, 1'b0, 3'b110, 3'b111, 3'b000, 3'b000, 3'b001);
    step("R10", 1'b0, 1'b0, 3'b110, 3'b000, 3'b000, 3'b000, 3'b011);
    step("R10", 1'b0, 1'b0, 3'b001, 3'b011, 3'b101, 3'b100, 3'b110);
    // mixed modes side by side
    for (int k = 0; k < 16; k++) begin
      step("R1", 1'b0, 1'b0, 3'(k * 5), 3'(k + 3), 3'b101, 3'(k), 3'(k * 3));
      step("R2", 1'b0, 1'b0, 3'(k * 3), 3'(k), 3'b010, 3'(k + 1), 3'(k * 7));
    end
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule